// File: doc/BRIEF.md
# Clamped integrate-and-fire neuron

A single spiking neuron for a discrete-time network. In each integration cycle the neuron sees a parallel bank of spike flags and one signed synapse weight per flag. A combinational sum network adds the weights of the flags that are set and adds the stored potential to that sum. The clock edge that closes the cycle commits the result: the neuron either fires, or leaks, or stores the new potential, raised to a configured floor when it has fallen below it.

Firing and the floor act only on the complete sum of the cycle and never on a partial sum. Because of this, the order of the inputs inside a cycle cannot change the result. The floor parameter replaces a plain "no negative charge" switch: a floor of 0 gives that behaviour, and a negative floor lets the neuron carry a bounded negative charge. The floor must be a finite integer no greater than 0. A positive floor stops elaboration. The potential register is sized from the threshold and the floor, so a negative charge can never wrap.

Top module: `lif_clamp_neuron`

## Requirements
- R1: The sum of a cycle takes in only the weights whose spike flag is set. Weight i sits in bits [i*W_WIDTH +: W_WIDTH] of `synWeights` and is read as two's complement. A weight whose flag is clear has no effect on `potential` or `spikeOut`.
- R2: The fire decision uses only the total at the end of the cycle. Take threshold 10, inclusive mode and potential 0, and apply weights +5, +5, +5 and -9 in one cycle. The neuron does not fire and `potential` becomes 6.
- R3: The sum network and the stored potential never overflow. With every input at the largest positive weight, or at the most negative weight, the result is the correct fire decision or the correct clamped value, and `potential` stays inside [MIN_POT, THRESHOLD].
- R4: When THRESH_INCL is 1, the neuron fires when the total is greater than or equal to THRESHOLD. A total of THRESHOLD-1 does not fire.
- R5: When THRESH_INCL is 0, the neuron fires only when the total is strictly greater than THRESHOLD. A total equal to THRESHOLD is stored and does not fire.
- R6: On a fire, `spikeOut` is 1 for exactly the one cycle after the closing edge, and `potential` is 0 during that cycle.
- R7: A total that does not fire and is below MIN_POT is stored as MIN_POT. A total equal to MIN_POT is stored unchanged.
- R8: With MIN_POT = 0, a total that does not fire is never stored as a negative value.
- R9: While `leakEnable` is 1, a cycle that does not fire leaves `potential` at 0.
- R10: A synchronous active-high `rst` sets `potential` to 0 and `spikeOut` to 0 at the next edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Each rising edge closes one integration cycle |
| rst | input | 1 | Synchronous active-high reset |
| leakEnable | input | 1 | Clears the potential at the end of every cycle that does not fire |
| spikeIn | input | FAN_IN | One spike flag per synapse for the current cycle |
| synWeights | input | FAN_IN*W_WIDTH | Packed signed synapse weights |
| spikeOut | output | 1 | Spike from the cycle that just closed |
| potential | output | POT_W | Stored potential, signed |

## Verification
The assertions assume that `synWeights` holds valid two's-complement values of W_WIDTH bits. They also assume the block is elaborated with a threshold of at least 1 and a floor of at most 0, because the range bound on `potential` is only meaningful under those limits. The stimulus uses a threshold of 10, floors of -20 and 0, and weights between -32 and +31 only. It walks the extreme weights at both ends to reach the clamp and the largest sum. It drives inputs and reset only between clock edges, so that the leak and reset properties see stable values.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clearPot;  // fire or leak: next potential is 0
    logic loadMin;   // total fell below the floor
  } ctrlStrobes_t;

  // smallest signed width that holds both hi and lo
  function automatic int signedWidth(input int hi, input int lo);
    int b;
    b = 2;
    while ((((64'sd1 <<< (b - 1)) - 1) < hi) || (-(64'sd1 <<< (b - 1)) > lo))
      b++;
    return b;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/neuron_datapath.sv
module neuron_datapath
  import neuron_pkg::*;
#(
  parameter int FAN_IN      = 8,
  parameter int W_WIDTH     = 8,
  parameter int THRESHOLD   = 10,
  parameter int MIN_POT     = -64,
  parameter bit THRESH_INCL = 1'b1,
  parameter int POT_W       = 8,
  parameter int SUM_W       = 12,
  parameter int TOT_W       = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [FAN_IN-1:0]           spikeIn,
  input  logic [FAN_IN*W_WIDTH-1:0]   synWeights,
  input  ctrlStrobes_t                strobes,
  output logic                        fireReq,
  output logic                        belowMin,
  output logic signed [POT_W-1:0]     potential
);

  localparam logic signed [TOT_W-1:0] THR_T = TOT_W'(THRESHOLD);
  localparam logic signed [TOT_W-1:0] MIN_T = TOT_W'(MIN_POT);
  localparam logic signed [POT_W-1:0] MIN_P = POT_W'(MIN_POT);

  logic signed [SUM_W-1:0] termVal [FAN_IN];
  logic signed [SUM_W-1:0] weightSum;
  logic signed [TOT_W-1:0] total;

  // masked, sign-extended weight terms
  for (genvar i = 0; i < FAN_IN; i++) begin : gTerm
    logic signed [W_WIDTH-1:0] wRaw;
    assign wRaw       = synWeights[i*W_WIDTH +: W_WIDTH];
    assign termVal[i] = spikeIn[i] ? SUM_W'(wRaw) : '0;
  end

  // sum network; SUM_W leaves headroom for FAN_IN extreme terms
  always_comb begin
    weightSum = '0;
    for (int i = 0; i < FAN_IN; i++)
      weightSum = weightSum + termVal[i];
  end

  assign total = TOT_W'(potential) + TOT_W'(weightSum);

  // decisions are taken on the end-of-cycle total only
  if (THRESH_INCL) begin : gIncl
    assign fireReq = (total >= THR_T);
  end else begin : gExcl
    assign fireReq = (total > THR_T);
  end
  assign belowMin = (total < MIN_T);

  always_ff @(posedge clk) begin
    if (rst)                   potential <= '0;
    else if (strobes.clearPot) potential <= '0;
    else if (strobes.loadMin)  potential <= MIN_P;
    else                       potential <= POT_W'(total);
  end

endmodule

// File: rtl/neuron_control.sv
module neuron_control
  import neuron_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         leakEnable,
  input  logic         fireReq,
  input  logic         belowMin,
  output ctrlStrobes_t strobes,
  output logic         spikeOut
);

  // firing takes priority over leak, and both take priority over the clamp
  always_comb begin
    strobes.clearPot = fireReq | leakEnable;
    strobes.loadMin  = belowMin & ~(fireReq | leakEnable);
  end

  always_ff @(posedge clk) begin
    if (rst) spikeOut <= 1'b0;
    else     spikeOut <= fireReq;
  end

endmodule

// File: rtl/lif_clamp_neuron.sv
module lif_clamp_neuron
  import neuron_pkg::*;
#(
  parameter int FAN_IN      = 8,
  parameter int W_WIDTH     = 8,
  parameter int THRESHOLD   = 10,
  parameter int MIN_POT     = -64,
  parameter bit THRESH_INCL = 1'b1,
  localparam int POT_W      = signedWidth(THRESHOLD, MIN_POT),
  localparam int SUM_W      = W_WIDTH + $clog2(FAN_IN) + 1,
  localparam int TOT_W      = maxInt(POT_W, SUM_W) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      leakEnable,
  input  logic [FAN_IN-1:0]         spikeIn,
  input  logic [FAN_IN*W_WIDTH-1:0] synWeights,
  output logic                      spikeOut,
  output logic signed [POT_W-1:0]   potential
);

  // a floor above zero would change fire and leak semantics
  if (MIN_POT > 0) begin : gBadFloor
    $error("lif_clamp_neuron: MIN_POT must be <= 0");
  end

  ctrlStrobes_t strobes;
  logic         fireReq;
  logic         belowMin;

  neuron_datapath #(
    .FAN_IN     (FAN_IN),
    .W_WIDTH    (W_WIDTH),
    .THRESHOLD  (THRESHOLD),
    .MIN_POT    (MIN_POT),
    .THRESH_INCL(THRESH_INCL),
    .POT_W      (POT_W),
    .SUM_W      (SUM_W),
    .TOT_W      (TOT_W)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .spikeIn   (spikeIn),
    .synWeights(synWeights),
    .strobes   (strobes),
    .fireReq   (fireReq),
    .belowMin  (belowMin),
    .potential (potential)
  );

  neuron_control uCtl (
    .clk       (clk),
    .rst       (rst),
    .leakEnable(leakEnable),
    .fireReq   (fireReq),
    .belowMin  (belowMin),
    .strobes   (strobes),
    .spikeOut  (spikeOut)
  );

endmodule

// File: rtl/neuron_checker.sv
module neuron_checker #(
  parameter int THRESHOLD   = 10,
  parameter int MIN_POT     = -64,
  parameter bit THRESH_INCL = 1'b1,
  parameter int POT_W       = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    leakEnable,
  input logic                    spikeOut,
  input logic signed [POT_W-1:0] potential
);

  int potInt;
  assign potInt = int'(potential);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (potInt >= MIN_POT) && (THRESH_INCL ? (potInt < THRESHOLD) : (potInt <= THRESHOLD))); // R3
  AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (rst)
    potInt >= MIN_POT); // R7
  AST_SPIKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    spikeOut |-> (potential == '0)); // R6
  AST_LEAK_ZERO: assert property (@(posedge clk) disable iff (rst)
    leakEnable |=> (potential == '0)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> ((potential == '0) && !spikeOut)); // R10

endmodule

bind lif_clamp_neuron neuron_checker #(
  .THRESHOLD  (THRESHOLD),
  .MIN_POT    (MIN_POT),
  .THRESH_INCL(THRESH_INCL),
  .POT_W      (POT_W)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .leakEnable(leakEnable),
  .spikeOut  (spikeOut),
  .potential (potential)
);

// File: tb/sim_lif_clamp_neuron.sv
module sim_lif_clamp_neuron;

  localparam int CLK_PERIOD = 10;
  localparam int NIN = 4;
  localparam int WW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic leak0 = 1'b0;
  logic leak1 = 1'b0;
  logic [NIN-1:0] sp0 = '0, sp1 = '0;
  logic [NIN*WW-1:0] wt0 = '0, wt1 = '0;
  logic spike0, spike1;
  logic signed [5:0] pot0;
  logic signed [4:0] pot1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // threshold 10 inclusive, floor -20
  lif_clamp_neuron #(.FAN_IN(NIN), .W_WIDTH(WW), .THRESHOLD(10), .MIN_POT(-20),
                     .THRESH_INCL(1'b1)) u0 (
    .clk(clk), .rst(rst), .leakEnable(leak0), .spikeIn(sp0), .synWeights(wt0),
    .spikeOut(spike0), .potential(pot0));

  // threshold 10 strict, floor 0 (non-negative charge)
  lif_clamp_neuron #(.FAN_IN(NIN), .W_WIDTH(WW), .THRESHOLD(10), .MIN_POT(0),
                     .THRESH_INCL(1'b0)) u1 (
    .clk(clk), .rst(rst), .leakEnable(leak1), .spikeIn(sp1), .synWeights(wt1),
    .spikeOut(spike1), .potential(pot1));

  // columns: spike flags, w0, w1, w2, w3, expected spike, expected potential
  localparam int NV = 11;
  localparam int VEC [NV][7] = '{
    '{4'b1111,   5,   5,   5,  -9, 0,   6},  // R2 order-free total
    '{4'b0001,   4,   0,   0,   0, 1,   0},  // R4 exactly 10 fires
    '{4'b0000,  31,  31,  31,  31, 0,   0},  // R6 spike lasts one cycle
    '{4'b1111,  -9,  -9,  -9,  -9, 0, -20},  // R7 clamp
    '{4'b0011,   3,   2,   0,   0, 0, -15},
    '{4'b1111,  31,  31, -32, -30, 0, -15},
    '{4'b1111,  31,  31,  -4,   0, 1,   0},  // R3 large sum
    '{4'b0001,   9,   0,   0,   0, 0,   9},  // R4 9 below threshold
    '{4'b0010,   0, -29,   0,   0, 0, -20},  // R7 equal to floor
    '{4'b0100,   0,   0,  30,   0, 1,   0},
    '{4'b1010,  31,  10,  31,   0, 1,   0}   // R1 masked weights
  };

  function automatic logic [NIN*WW-1:0] packW(int a, int b, int c, int d);
    return {WW'(d), WW'(c), WW'(b), WW'(a)};
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    #2;
    sp0 = 4'b1111; wt0 = packW(31, 31, 31, 31);
    tick(); tick();
    check("R10 reset potential", int'(pot0), 0);
    check("R10 reset spike", int'(spike0), 0);
    sp0 = '0;
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      sp0 = VEC[v][0][NIN-1:0];
      wt0 = packW(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      tick();
      check($sformatf("R1/R2/R4/R6/R7 vec%0d spike", v), int'(spike0), VEC[v][5]);
      check($sformatf("R1/R2/R4/R6/R7 vec%0d potential", v), int'(pot0), VEC[v][6]);
    end
    sp0 = '0;

    // R3 most negative weights on every input
    sp0 = 4'b1111; wt0 = packW(-32, -32, -32, -32);
    tick();
    check("R3 extreme negative clamp", int'(pot0), -20);
    sp0 = '0;
    tick();
    check("R3 floor held with no input", int'(pot0), -20);

    // R5 strict compare and R8 non-negative floor on u1
    sp1 = 4'b0111; wt1 = packW(4, 4, 2, 0);
    tick();
    check("R5 equal to threshold no spike", int'(spike1), 0);
    check("R5 equal to threshold stored", int'(pot1), 10);
    sp1 = 4'b0001; wt1 = packW(1, 0, 0, 0);
    tick();
    check("R5 above threshold spike", int'(spike1), 1);
    check("R5 potential after fire", int'(pot1), 0);
    sp1 = 4'b0001; wt1 = packW(-7, 0, 0, 0);
    tick();
    check("R8 negative clamped to zero", int'(pot1), 0);
    sp1 = 4'b0001; wt1 = packW(3, 0, 0, 0);
    tick();
    check("R8 positive accumulates", int'(pot1), 3);
    sp1 = '0;

    // R9 leak on u0 (potential now -20)
    leak0 = 1'b1;
    sp0 = 4'b0001; wt0 = packW(27, 0, 0, 0);
    tick();
    check("R9 leak clears potential", int'(pot0), 0);
    check("R9 leak no spike", int'(spike0), 0);
    wt0 = packW(12, 0, 0, 0);
    tick();
    check("R9 fire under leak", int'(spike0), 1);
    leak0 = 1'b0;
    wt0 = packW(7, 0, 0, 0);
    tick();
    check("R9 no leak keeps charge", int'(pot0), 7);

    // R10 reset right after a fire
    wt0 = packW(5, 0, 0, 0);
    tick();
    check("R6 fire before reset", int'(spike0), 1);
    rst = 1'b1;
    wt0 = packW(7, 0, 0, 0);
    tick();
    check("R10 reset clears spike", int'(spike0), 0);
    check("R10 reset clears potential", int'(pot0), 0);
    rst = 1'b0;
    sp0 = '0;
    tick();
    summary();
  end

endmodule